// File: doc/BRIEF.md
# Three-Channel Timer Clock Router with Block Sync

This block sits between a shared prescaler and three timer channels. It decides, for each channel, which event advances that channel's counter. Each channel has one external line: XC0, XC1 and XC2. A 2-bit routing field per line chooses what drives that line. The choices are an off-chip clock pin, a constant low, or the A-side output of one of the two other channels, which lets channels be chained.

Each channel then picks its count source with a 3-bit select. The options are four internal divided clocks, a slow-clock enable, or one of the three external lines. The channel can invert the chosen clock so that it counts on the opposite edge. It can also gate counting with one of the external lines, so that counts pass only while that line is high.

All count sources leave the block as single-cycle tick enables in the system clock domain. A block-wide sync strobe produces a reset pulse to all three channel counters in the same cycle.

Top module: `tc_clock_router`

## Requirements
- R1: While reset is asserted and after its release, before any stimulus, `ch_tick`, `ch_sync` and `xline` are all zero.
- R2: Each channel has a 3-bit select, where channel k uses `clk_sel[3k+2:3k]`. With gating off and invert clear, codes 0, 1, 2 and 3 produce exactly one tick every 2, 8, 32 and 128 system clocks. Code 4 produces a tick in the cycle after each cycle in which `slow_tick` is high.
- R3: For codes 0 to 3, setting the channel's invert bit (`clk_inv[k]`) keeps the tick rate but moves every tick by half the divider period. For code 4 the invert bit has no effect.
- R4: Codes 5, 6 and 7 select XC0, XC1 and XC2. With invert clear, the channel ticks once per rising edge of the line. With invert set, it ticks once per falling edge. A rising edge on an off-chip pin routed to a line gives a tick 4 cycles after the pin changes. A rising edge on a routed channel output gives a tick 2 cycles after that output changes.
- R5: Line k is routed by `route_sel[2k+1:2k]`. Code 0 selects `ext_pin[k]`. Code 1 holds the line low. Code 2 selects the channel output `chan_out_a` of the lowest-numbered other channel. Code 3 selects the output of the highest-numbered other channel. So XC0 uses channels 1 and 2, XC1 uses 0 and 2, and XC2 uses 0 and 1.
- R6: Gating for channel k is set by `gate_sel[2k+1:2k]`. Code 0 means no gating. Codes 1, 2 and 3 gate with XC0, XC1 and XC2. While the gating line is low the channel produces no ticks. While it is high, ticks pass unchanged.
- R7: A high `sync_cmd` in one cycle drives all three `ch_sync` bits high in the next cycle. `ch_sync` is zero in any cycle that follows a cycle without `sync_cmd`.
- R8: `xline[k]` shows the routed level of line k. It follows a routed channel output after 1 cycle and a routed off-chip pin after 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 3 | Off-chip clock pins, one per line, asynchronous |
| chan_out_a | input | 3 | A-side outputs of channels 0 to 2, system clock domain |
| slow_tick | input | 1 | Slow-clock enable, one cycle wide |
| route_sel | input | 6 | Routing field per external line, 2 bits each |
| clk_sel | input | 9 | Count source select per channel, 3 bits each |
| clk_inv | input | 3 | Clock invert per channel |
| gate_sel | input | 6 | Gating line select per channel, 2 bits each |
| sync_cmd | input | 1 | Block-wide counter sync strobe |
| ch_tick | output | 3 | Count enable per channel, one cycle per event |
| ch_sync | output | 3 | Counter reset pulse per channel |
| xline | output | 3 | Routed level of XC0 to XC2 |

## Verification
Each fault in this block shows up at a particular port, and some show up much faster than others.

- **Routing fault.** If a routing field decodes to the wrong sibling, a tick appears on the wrong channel. It shows within two cycles of a sibling output edge, and `xline` shows the wrong level one cycle after that edge.
- **Divider or invert fault.** A wrong divider tap or invert decode shows as a wrong tick count or phase. It is visible only over a full divider period, which can take up to 128 cycles. The bench therefore counts ticks over windows that are a multiple of the longest period.
- **Sync fault.** A stuck or missing sync pulse shows on `ch_sync` in the very next cycle.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int NUM_CH  = 3;
    localparam int NUM_DIV = 4;
    localparam int CSEL_W  = 3;
    localparam int FLD_W   = 2;

    typedef enum logic [FLD_W-1:0] {
        RT_PIN    = 2'd0,
        RT_OFF    = 2'd1,
        RT_SIB_LO = 2'd2,
        RT_SIB_HI = 2'd3
    } route_e;

    localparam logic [CSEL_W-1:0] CS_SLOW = 3'd4;
    localparam logic [CSEL_W-1:0] CS_X0   = 3'd5;
    localparam logic [CSEL_W-1:0] CS_X1   = 3'd6;
    localparam logic [CSEL_W-1:0] CS_X2   = 3'd7;

    // lowest-numbered channel other than k
    function automatic int sib_lo(int k);
        return (k == 0) ? 1 : 0;
    endfunction

    // highest-numbered channel other than k
    function automatic int sib_hi(int k);
        return (k == NUM_CH - 1) ? NUM_CH - 2 : NUM_CH - 1;
    endfunction
endpackage

// File: rtl/tcr_prescaler.sv
module tcr_prescaler
    import tcr_pkg::*;
#(
    parameter int DIV_LOG_FIRST = 1,
    parameter int DIV_LOG_STEP  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_DIV-1:0] div_rise,
    output logic [NUM_DIV-1:0] div_fall
);
    localparam int CNT_W = DIV_LOG_FIRST + (NUM_DIV - 1) * DIV_LOG_STEP;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // tap k divides by 2**L; the rise point is the wrap and the fall point is half a period earlier
    for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
        localparam int L = DIV_LOG_FIRST + k * DIV_LOG_STEP;
        localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (L - 1)) - 1);
        assign div_rise[k] = &st_q.cnt[L-1:0];
        assign div_fall[k] = (st_q.cnt[L-1:0] == HALF_M1[L-1:0]);
    end

endmodule

// File: rtl/tcr_xroute.sv
module tcr_xroute
    import tcr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ext_pin,
    input  logic [NUM_CH-1:0]       chan_out_a,
    input  logic [NUM_CH*FLD_W-1:0] route_sel,
    output logic [NUM_CH-1:0]       xlvl,
    output logic [NUM_CH-1:0]       xrise,
    output logic [NUM_CH-1:0]       xfall
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_CH-1:0] sync;
        logic [NUM_CH-1:0]                  line;
        logic [NUM_CH-1:0]                  prev;
    } xr_st_t;

    xr_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = ext_pin;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        for (int k = 0; k < NUM_CH; k++) begin
            case (route_e'(route_sel[k*FLD_W +: FLD_W]))
                RT_PIN:    st_d.line[k] = st_q.sync[SYNC_STAGES-1][k];
                RT_OFF:    st_d.line[k] = 1'b0;
                RT_SIB_LO: st_d.line[k] = chan_out_a[sib_lo(k)];
                default:   st_d.line[k] = chan_out_a[sib_hi(k)];
            endcase
        end
        st_d.prev = st_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xlvl  = st_q.line;
    assign xrise = st_q.line & ~st_q.prev;
    assign xfall = ~st_q.line & st_q.prev;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        AST_OFF_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (route_sel[k*FLD_W +: FLD_W] == 2'd1) |=> !xlvl[k]); // R5
        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            xrise[k] |=> !xrise[k]); // R4
    end

endmodule

// File: rtl/tcr_chan_sel.sv
module tcr_chan_sel
    import tcr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIV-1:0] div_rise,
    input  logic [NUM_DIV-1:0] div_fall,
    input  logic               slow_tick,
    input  logic [NUM_CH-1:0]  xlvl,
    input  logic [NUM_CH-1:0]  xrise,
    input  logic [NUM_CH-1:0]  xfall,
    input  logic [CSEL_W-1:0]  sel,
    input  logic               inv,
    input  logic [FLD_W-1:0]   gate,
    output logic               tick
);
    typedef struct packed {
        logic tick;
    } cs_st_t;

    cs_st_t st_d, st_q;
    logic   src;
    logic   gate_open;

    always_comb begin
        case (sel)
            CS_SLOW: src = slow_tick;
            CS_X0:   src = inv ? xfall[0] : xrise[0];
            CS_X1:   src = inv ? xfall[1] : xrise[1];
            CS_X2:   src = inv ? xfall[2] : xrise[2];
            default: src = inv ? div_fall[sel[1:0]] : div_rise[sel[1:0]];
        endcase
        case (gate)
            2'd1:    gate_open = xlvl[0];
            2'd2:    gate_open = xlvl[1];
            2'd3:    gate_open = xlvl[2];
            default: gate_open = 1'b1;
        endcase
        st_d      = st_q;
        st_d.tick = src & gate_open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate == 2'd1 && !xlvl[0]) || (gate == 2'd2 && !xlvl[1]) ||
         (gate == 2'd3 && !xlvl[2])) |=> !tick); // R6
    AST_SLOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CS_SLOW && gate == 2'd0 && slow_tick) |=> tick); // R2

endmodule

// File: rtl/tc_clock_router.sv
module tc_clock_router
    import tcr_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int DIV_LOG_FIRST = 1,
    parameter int DIV_LOG_STEP  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  ext_pin,
    input  logic [2:0]  chan_out_a,
    input  logic        slow_tick,
    input  logic [5:0]  route_sel,
    input  logic [8:0]  clk_sel,
    input  logic [2:0]  clk_inv,
    input  logic [5:0]  gate_sel,
    input  logic        sync_cmd,
    output logic [2:0]  ch_tick,
    output logic [2:0]  ch_sync,
    output logic [2:0]  xline
);
    typedef struct packed {
        logic sync;
    } top_st_t;

    top_st_t             st_d, st_q;
    logic [NUM_DIV-1:0]  div_rise, div_fall;
    logic [NUM_CH-1:0]   xlvl, xrise, xfall;

    tcr_prescaler #(
        .DIV_LOG_FIRST (DIV_LOG_FIRST),
        .DIV_LOG_STEP  (DIV_LOG_STEP)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_rise (div_rise),
        .div_fall (div_fall)
    );

    tcr_xroute #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_xr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (ext_pin),
        .chan_out_a (chan_out_a),
        .route_sel  (route_sel),
        .xlvl       (xlvl),
        .xrise      (xrise),
        .xfall      (xfall)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        tcr_chan_sel u_cs (
            .clk       (clk),
            .rst_n     (rst_n),
            .div_rise  (div_rise),
            .div_fall  (div_fall),
            .slow_tick (slow_tick),
            .xlvl      (xlvl),
            .xrise     (xrise),
            .xfall     (xfall),
            .sel       (clk_sel[k*CSEL_W +: CSEL_W]),
            .inv       (clk_inv[k]),
            .gate      (gate_sel[k*FLD_W +: FLD_W]),
            .tick      (ch_tick[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.sync = sync_cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_sync = {NUM_CH{st_q.sync}};
    assign xline   = xlvl;

    AST_SYNC_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
        sync_cmd |=> (ch_sync == 3'b111)); // R7
    AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_cmd |=> (ch_sync == 3'b000)); // R7

endmodule

// File: tb/tc_clock_router_bench.sv
module tc_clock_router_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ext_pin = '0;
    logic [2:0] chan_out_a = '0;
    logic       slow_tick = 1'b0;
    logic [5:0] route_sel = '0;
    logic [8:0] clk_sel = '0;
    logic [2:0] clk_inv = '0;
    logic [5:0] gate_sel = '0;
    logic       sync_cmd = 1'b0;
    logic [2:0] ch_tick, ch_sync, xline;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tc_clock_router u_tc_clock_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (ext_pin),
        .chan_out_a (chan_out_a),
        .slow_tick  (slow_tick),
        .route_sel  (route_sel),
        .clk_sel    (clk_sel),
        .clk_inv    (clk_inv),
        .gate_sel   (gate_sel),
        .sync_cmd   (sync_cmd),
        .ch_tick    (ch_tick),
        .ch_sync    (ch_sync),
        .xline      (xline)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic count_ticks(int ch, int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (ch_tick[ch]) c++;
        end
    endtask

    task automatic quiet_all();
        ext_pin = '0; chan_out_a = '0; slow_tick = 1'b0; route_sel = '0;
        clk_sel = '0; clk_inv = '0; gate_sel = '0; sync_cmd = 1'b0;
        step(6);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 tick in reset", ch_tick, 0);
        chk("R1 sync in reset", ch_sync, 0);
        chk("R1 xline in reset", xline, 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 sync after reset", ch_sync, 0);
        chk("R1 xline after reset", xline, 0);
    endtask

    task automatic t_div_rates();
        int c;
        for (int code = 0; code < 4; code++) begin
            clk_sel[2:0] = 3'(code);
            clk_inv[0]   = 1'b0;
            step(4);
            count_ticks(0, 256, c);
            chk($sformatf("R2 divider code %0d", code), c, 256 >> (1 + 2*code));
        end
    endtask

    task automatic t_slow();
        for (int iv = 0; iv < 2; iv++) begin
            clk_sel[8:6] = 3'd4;
            clk_inv[2]   = 1'(iv);
            step(4);
            chk("R2 slow idle", ch_tick[2], 0);
            slow_tick = 1'b1;
            step(1);
            slow_tick = 1'b0;
            chk(iv ? "R3 slow tick ignores invert" : "R2 slow tick passes", ch_tick[2], 1);
            step(1);
            chk("R2 slow tick single", ch_tick[2], 0);
        end
        clk_inv[2] = 1'b0;
    endtask

    task automatic t_invert();
        int c;
        int guard;
        int both;
        clk_sel[2:0] = 3'd1; clk_inv[0] = 1'b0;
        clk_sel[5:3] = 3'd1; clk_inv[1] = 1'b1;
        step(10);
        guard = 0;
        while (!ch_tick[0] && guard < 20) begin
            step(1);
            guard++;
        end
        chk("R3 normal tick found", ch_tick[0], 1);
        chk("R3 inverted not coincident", ch_tick[1], 0);
        step(4);
        chk("R3 inverted half period later", ch_tick[1], 1);
        chk("R3 normal absent mid period", ch_tick[0], 0);
        both = 0;
        c = 0;
        for (int i = 0; i < 64; i++) begin
            step(1);
            if (ch_tick[1]) c++;
            if (ch_tick[0] && ch_tick[1]) both++;
        end
        chk("R3 inverted rate", c, 8);
        chk("R3 never coincident", both, 0);
        clk_inv = '0;
    endtask

    task automatic t_ext_pin();
        int c;
        route_sel = 6'b00_00_00;
        clk_sel[2:0] = 3'd5; clk_inv[0] = 1'b0;
        clk_sel[5:3] = 3'd6; clk_inv[1] = 1'b1;
        step(6);
        ext_pin[0] = 1'b1;
        step(2);
        chk("R8 pin line not yet", xline[0], 0);
        step(1);
        chk("R8 pin line after 3", xline[0], 1);
        chk("R4 pin tick not yet", ch_tick[0], 0);
        step(1);
        chk("R4 pin tick after 4", ch_tick[0], 1);
        step(1);
        chk("R4 pin tick single", ch_tick[0], 0);
        ext_pin[0] = 1'b0;
        count_ticks(0, 8, c);
        chk("R4 falling ignored when not inverted", c, 0);
        ext_pin[1] = 1'b1;
        count_ticks(1, 8, c);
        chk("R4 rising ignored when inverted", c, 0);
        ext_pin[1] = 1'b0;
        count_ticks(1, 8, c);
        chk("R4 falling counted when inverted", c, 1);
        clk_inv = '0;
    endtask

    task automatic t_route_off();
        int c;
        route_sel[1:0] = 2'd1;
        clk_sel[2:0]   = 3'd5;
        step(4);
        c = 0;
        for (int i = 0; i < 4; i++) begin
            ext_pin[0] = 1'b1;
            step(5);
            if (ch_tick[0] || xline[0]) c++;
            ext_pin[0] = 1'b0;
            step(5);
        end
        chk("R5 off line gives no ticks", c, 0);
        chk("R5 off line low", xline[0], 0);
    endtask

    task automatic t_route_sib();
        int c;
        int sib;
        for (int ln = 0; ln < 3; ln++) begin
            for (int code = 2; code < 4; code++) begin
                sib = -1;
                for (int o = 0; o < 3; o++) begin
                    if (o != ln) begin
                        if (code == 2 && sib < 0) sib = o;
                        if (code == 3) sib = o;
                    end
                end
                route_sel = '0;
                route_sel[ln*2 +: 2] = 2'(code);
                clk_sel = '0;
                clk_sel[ln*3 +: 3] = 3'(5 + ln);
                chan_out_a = '0;
                step(4);
                for (int src = 0; src < 3; src++) begin
                    chan_out_a[src] = 1'b1;
                    step(1);
                    chk($sformatf("R8 line %0d code %0d src %0d level", ln, code, src),
                        xline[ln], (src == sib) ? 1 : 0);
                    c = 0;
                    for (int i = 0; i < 5; i++) begin
                        step(1);
                        if (ch_tick[ln]) c++;
                    end
                    chk($sformatf("R5 line %0d code %0d src %0d ticks", ln, code, src),
                        c, (src == sib) ? 1 : 0);
                    chan_out_a[src] = 1'b0;
                    step(4);
                end
            end
        end
    endtask

    task automatic t_sib_latency();
        route_sel = '0;
        route_sel[3:2] = 2'd3;
        clk_sel = '0;
        clk_sel[5:3] = 3'd6;
        step(4);
        chan_out_a[2] = 1'b1;
        step(1);
        chk("R4 sibling tick not after 1", ch_tick[1], 0);
        step(1);
        chk("R4 sibling tick after 2", ch_tick[1], 1);
        chan_out_a[2] = 1'b0;
        step(4);
    endtask

    task automatic t_gate();
        int c;
        route_sel = '0;
        route_sel[3:2] = 2'd2;
        clk_sel = '0;
        gate_sel = '0;
        gate_sel[1:0] = 2'd2;
        chan_out_a = '0;
        step(4);
        count_ticks(0, 64, c);
        chk("R6 gate low blocks", c, 0);
        chan_out_a[0] = 1'b1;
        step(4);
        count_ticks(0, 64, c);
        chk("R6 gate high passes", c, 32);
        chan_out_a[0] = 1'b0;
        gate_sel = '0;
        step(4);
        count_ticks(0, 64, c);
        chk("R6 no gating passes", c, 32);
    endtask

    task automatic t_sync();
        chk("R7 sync idle", ch_sync, 0);
        sync_cmd = 1'b1;
        step(1);
        sync_cmd = 1'b0;
        chk("R7 sync pulse all channels", ch_sync, 7);
        step(1);
        chk("R7 sync pulse ends", ch_sync, 0);
        sync_cmd = 1'b1;
        step(2);
        sync_cmd = 1'b0;
        chk("R7 sync held two cycles", ch_sync, 7);
        step(1);
        chk("R7 sync released", ch_sync, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        quiet_all();
        t_div_rates();
        quiet_all();
        t_slow();
        quiet_all();
        t_invert();
        quiet_all();
        t_ext_pin();
        quiet_all();
        t_route_off();
        quiet_all();
        t_route_sib();
        quiet_all();
        t_sib_latency();
        quiet_all();
        t_gate();
        quiet_all();
        t_sync();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

endmodule